// File: doc/BRIEF.md
# Memory-Device Boundary-Scan Test Port

This block is the test access port of a synchronous memory device. A 16-state controller is stepped by a test clock and a mode-select line. It moves bits serially between a data input and a data output through one of several registers. A 3-bit instruction picks the register and sets how the device data bus behaves. The test logic runs beside the memory datapath. A controller reset affects only the test registers and the bus enable that they drive.

The selectable data registers are a one-bit bypass stage, a 32-bit hardwired identity word and a boundary register. The boundary register has a parameterized length of at least 48 cells and a parallel preload latch behind it. Capturing into the boundary register samples the parallel pin inputs. The preload latch drives the parallel pin outputs during external test. One boundary cell, number 47 by default, controls whether the device data bus is enabled during external test. Power-on reset is asynchronous and active low.

Top module: `scan_port`

## Requirements
- R1: After power-on reset, the controller is in Test-Logic-Reset and the instruction is identity (001). From any state, five consecutive rising test-clock edges with `tms` high reach Test-Logic-Reset. The first rising edge spent in that state reloads the identity instruction.
- R2: `tms` and `tdi` are sampled on the rising test-clock edge. `tdo` and `tdo_oe` change only on the falling edge. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R3: Capture-IR loads 3'b001 into the instruction shift stage. The bits appear on `tdo` LSB first as 1, 0, 0.
- R4: Every shift moves `tdi` into the most significant bit of the selected register and presents its least significant bit on `tdo`. Data therefore comes out delayed by the register length.
- R5: Code 111 selects the one-bit bypass register, and Capture-DR clears that bit to 0.
- R6: Code 001 selects the 32-bit identity register, and Capture-DR loads the `ID_VALUE` parameter into it. The value is shifted out LSB first.
- R7: The reserved codes 011, 101 and 110 act as bypass, with a one-bit register captured to 0. They keep `q_oe` at 1 and `extest_drive` at 0.
- R8: Codes 100 (sample/preload), 000 (external test) and 010 (sample with bus off) select the boundary register. Capture-DR loads `pin_in`. On leaving Update-DR, the shifted contents are copied to the preload latch on `pin_out`.
- R9: While code 010 is the current instruction, `q_oe` is 0. This lasts from the Update-IR that installs the code until the next Update-IR.
- R10: While code 000 is the current instruction, `extest_drive` is 1 and `q_oe` equals preload cell `OE_CELL`.
- R11: Power-on reset and every rising edge in Test-Logic-Reset preset the preload latch to all zeros except cell `OE_CELL`, which is set to 1.
- R12: Under codes 001, 100 and 111, `q_oe` is 1 and `extest_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Enable for `tdo`, 1 only while shifting |
| pin_in | input | BSR_LEN | Parallel pin values captured into the boundary register |
| pin_out | output | BSR_LEN | Preload latch contents for driving the pins |
| extest_drive | output | 1 | 1 while the external-test instruction is current |
| q_oe | output | 1 | Enable for the device data output bus |

## Verification
The bench drives `tms` and `tdi`, then samples every output 15 ns after each rising edge. A sample taken there sees the state entered at that edge, plus the falling-edge `tdo` produced from it. In Shift-DR and Shift-IR, the first captured bit is therefore read right after the edge that enters the shift state. Each following bit is read one edge later.

`q_oe`, `extest_drive` and `ir` reflect a new instruction after the edge that leaves Update-IR. `pin_out` changes after the edge that leaves Update-DR. The Test-Logic-Reset presets take effect after the first edge spent in that state, and the checks are placed at those points. The falling-edge timing of `tdo_oe` is checked separately, by sampling 2 ns and again 15 ns after the edge that enters Shift-DR.

// File: rtl/scan_pkg.sv
package scan_pkg;

   localparam int IR_W = 3;
   typedef logic [IR_W-1:0] opcode_t;

   localparam opcode_t OP_EXTEST  = 3'b000;
   localparam opcode_t OP_IDCODE  = 3'b001;
   localparam opcode_t OP_SAMPLEZ = 3'b010;
   localparam opcode_t OP_SAMPLE  = 3'b100;
   localparam opcode_t OP_BYPASS  = 3'b111;
   localparam opcode_t IR_CAPTURE = 3'b001;

   typedef enum logic [3:0] {
      ST_EX2_DR   = 4'h0, ST_EX1_DR = 4'h1, ST_SH_DR  = 4'h2, ST_PAUSE_DR = 4'h3,
      ST_SEL_IR   = 4'h4, ST_UPD_DR = 4'h5, ST_CAP_DR = 4'h6, ST_SEL_DR   = 4'h7,
      ST_EX2_IR   = 4'h8, ST_EX1_IR = 4'h9, ST_SH_IR  = 4'hA, ST_PAUSE_IR = 4'hB,
      ST_IDLE     = 4'hC, ST_UPD_IR = 4'hD, ST_CAP_IR = 4'hE, ST_TLR      = 4'hF
   } tap_state_e;

   typedef enum logic [1:0] {SEL_BYPASS, SEL_IDENT, SEL_BOUND} dr_sel_e;

   function automatic dr_sel_e decode_sel(input opcode_t op);
      case (op)
         OP_IDCODE:                         return SEL_IDENT;
         OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE:  return SEL_BOUND;
         default:                           return SEL_BYPASS;
      endcase
   endfunction

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      case (s)
         ST_TLR:      return m ? ST_TLR    : ST_IDLE;
         ST_IDLE:     return m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR:   return m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR:   return m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:    return m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR:   return m ? ST_UPD_DR : ST_PAUSE_DR;
         ST_PAUSE_DR: return m ? ST_EX2_DR : ST_PAUSE_DR;
         ST_EX2_DR:   return m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR:   return m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR:   return m ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR:   return m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:    return m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR:   return m ? ST_UPD_IR : ST_PAUSE_IR;
         ST_PAUSE_IR: return m ? ST_EX2_IR : ST_PAUSE_IR;
         ST_EX2_IR:   return m ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR:   return m ? ST_SEL_DR : ST_IDLE;
         default:     return ST_TLR;
      endcase
   endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell #(
   parameter logic PRESET = 1'b0
) (
   input  logic tck,
   input  logic por_n,
   input  logic cap,
   input  logic shf,
   input  logic upd,
   input  logic tlr,
   input  logic par_in,
   input  logic ser_in,
   output logic ser_out,
   output logic pre_out
);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         ser_out <= 1'b0;
         pre_out <= PRESET;
      end else begin
         if (cap)      ser_out <= par_in;
         else if (shf) ser_out <= ser_in;
         if (tlr)      pre_out <= PRESET;
         else if (upd) pre_out <= ser_out;
      end
   end

endmodule

// File: rtl/tap_fsm.sv
module tap_fsm
   import scan_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state <= ST_TLR;
      else        state <= tap_next(state, tms);
   end

endmodule

// File: rtl/scan_ir.sv
module scan_ir
   import scan_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  tap_state_e state,
   input  logic       tdi,
   output opcode_t    ir,
   output opcode_t    ir_sh
);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         ir    <= OP_IDCODE;
         ir_sh <= IR_CAPTURE;
      end else begin
         case (state)
            ST_TLR:    ir    <= OP_IDCODE;
            ST_CAP_IR: ir_sh <= IR_CAPTURE;
            ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            ST_UPD_IR: ir    <= ir_sh;
            default:   ;
         endcase
      end
   end

endmodule

// File: rtl/scan_dr.sv
module scan_dr
   import scan_pkg::*;
#(
   parameter int          BSR_LEN  = 48,
   parameter int          OE_CELL  = 47,
   parameter int          ID_W     = 32,
   parameter logic [31:0] ID_VALUE = 32'h0C2E_5067
) (
   input  logic               tck,
   input  logic               por_n,
   input  tap_state_e         state,
   input  opcode_t            ir,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] pin_in,
   output logic               dr_lsb,
   output logic               byp_bit,
   output logic [BSR_LEN-1:0] preload
);

   localparam logic [ID_W-1:0] ID_INIT = ID_W'(ID_VALUE);

   dr_sel_e             sel;
   logic                cap, shf, upd, in_tlr;
   logic [ID_W-1:0]     id_sh;
   logic [BSR_LEN-1:0]  bsr_sh;
   logic [BSR_LEN-1:0]  chain_in;

   assign sel    = decode_sel(ir);
   assign cap    = (state == ST_CAP_DR);
   assign shf    = (state == ST_SH_DR);
   assign upd    = (state == ST_UPD_DR);
   assign in_tlr = (state == ST_TLR);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         byp_bit <= 1'b0;
         id_sh   <= '0;
      end else begin
         if (sel == SEL_BYPASS) begin
            if (cap)      byp_bit <= 1'b0;
            else if (shf) byp_bit <= tdi;
         end
         if (sel == SEL_IDENT) begin
            if (cap)      id_sh <= ID_INIT;
            else if (shf) id_sh <= {tdi, id_sh[ID_W-1:1]};
         end
      end
   end

   for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
      if (i == BSR_LEN - 1) begin : g_head
         assign chain_in[i] = tdi;
      end else begin : g_body
         assign chain_in[i] = bsr_sh[i+1];
      end
      scan_cell #(.PRESET(i == OE_CELL)) u_cell (
         .tck    (tck),
         .por_n  (por_n),
         .cap    (cap && sel == SEL_BOUND),
         .shf    (shf && sel == SEL_BOUND),
         .upd    (upd && sel == SEL_BOUND),
         .tlr    (in_tlr),
         .par_in (pin_in[i]),
         .ser_in (chain_in[i]),
         .ser_out(bsr_sh[i]),
         .pre_out(preload[i])
      );
   end

   always_comb begin
      case (sel)
         SEL_IDENT: dr_lsb = id_sh[0];
         SEL_BOUND: dr_lsb = bsr_sh[0];
         default:   dr_lsb = byp_bit;
      endcase
   end

endmodule

// File: rtl/scan_port.sv
module scan_port
   import scan_pkg::*;
#(
   parameter int          BSR_LEN  = 48,
   parameter int          OE_CELL  = 47,
   parameter logic [31:0] ID_VALUE = 32'h0C2E_5067
) (
   input  logic               tck,
   input  logic               por_n,
   input  logic               tms,
   input  logic               tdi,
   output logic               tdo,
   output logic               tdo_oe,
   input  logic [BSR_LEN-1:0] pin_in,
   output logic [BSR_LEN-1:0] pin_out,
   output logic               extest_drive,
   output logic               q_oe
);

   localparam int MIN_LEN = 48;

   if (BSR_LEN < MIN_LEN) begin : g_bad_len
      $error("scan_port: BSR_LEN must be at least 48");
   end
   if (OE_CELL >= BSR_LEN || OE_CELL < 0) begin : g_bad_cell
      $error("scan_port: OE_CELL must lie inside the boundary register");
   end
   if (ID_VALUE[0] != 1'b1) begin : g_bad_id
      $error("scan_port: identity value must have bit 0 set");
   end

   tap_state_e state;
   opcode_t    ir, ir_sh;
   logic       dr_lsb, byp_bit;

   tap_fsm u_fsm (
      .tck  (tck),
      .por_n(por_n),
      .tms  (tms),
      .state(state)
   );

   scan_ir u_ir (
      .tck  (tck),
      .por_n(por_n),
      .state(state),
      .tdi  (tdi),
      .ir   (ir),
      .ir_sh(ir_sh)
   );

   scan_dr #(
      .BSR_LEN (BSR_LEN),
      .OE_CELL (OE_CELL),
      .ID_VALUE(ID_VALUE)
   ) u_dr (
      .tck    (tck),
      .por_n  (por_n),
      .state  (state),
      .ir     (ir),
      .tdi    (tdi),
      .pin_in (pin_in),
      .dr_lsb (dr_lsb),
      .byp_bit(byp_bit),
      .preload(pin_out)
   );

   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         case (state)
            ST_SH_IR: begin tdo <= ir_sh[0]; tdo_oe <= 1'b1; end
            ST_SH_DR: begin tdo <= dr_lsb;   tdo_oe <= 1'b1; end
            default:  tdo_oe <= 1'b0;
         endcase
      end
   end

   assign extest_drive = (ir == OP_EXTEST);

   always_comb begin
      case (ir)
         OP_SAMPLEZ: q_oe = 1'b0;
         OP_EXTEST:  q_oe = pin_out[OE_CELL];
         default:    q_oe = 1'b1;
      endcase
   end

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
   import scan_pkg::*;
#(
   parameter int BSR_LEN = 48,
   parameter int OE_CELL = 47
) (
   input logic               tck,
   input logic               por_n,
   input logic               tms,
   input logic               tdo_oe,
   input logic               q_oe,
   input logic [BSR_LEN-1:0] pin_out,
   input tap_state_e         state,
   input opcode_t            ir,
   input opcode_t            ir_sh,
   input logic               byp_bit
);

   logic [2:0] ones;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)          ones <= 3'd0;
      else if (!tms)       ones <= 3'd0;
      else if (ones != 3'd5) ones <= ones + 3'd1;
   end

   assert_five_high_R1: assert property (@(posedge tck) disable iff (!por_n)
      (ones == 3'd5) |-> (state == ST_TLR));

   assert_reset_idcode_R1: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_TLR) |=> (ir == OP_IDCODE));

   assert_oe_shift_only_R2: assert property (@(posedge tck) disable iff (!por_n)
      tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

   assert_capture_ir_R3: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_CAP_IR) |=> (ir_sh[1:0] == 2'b01));

   assert_bypass_clear_R5: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_CAP_DR && decode_sel(ir) == SEL_BYPASS) |=> !byp_bit);

   assert_samplez_off_R9: assert property (@(posedge tck) disable iff (!por_n)
      (ir == OP_SAMPLEZ) |-> !q_oe);

   assert_ir_hold_R9: assert property (@(posedge tck) disable iff (!por_n)
      (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir));

   assert_extest_oe_R10: assert property (@(posedge tck) disable iff (!por_n)
      (ir == OP_EXTEST) |-> (q_oe == pin_out[OE_CELL]));

endmodule

bind scan_port scan_port_chk #(.BSR_LEN(BSR_LEN), .OE_CELL(OE_CELL)) u_chk (
   .tck    (tck),
   .por_n  (por_n),
   .tms    (tms),
   .tdo_oe (tdo_oe),
   .q_oe   (q_oe),
   .pin_out(pin_out),
   .state  (state),
   .ir     (ir),
   .ir_sh  (ir_sh),
   .byp_bit(byp_bit)
);

// File: tb/tb_scan_port.sv
module tb_scan_port;

   localparam int          BLEN = 48;
   localparam int          OEC  = 47;
   localparam logic [31:0] ID   = 32'h3A5C_9E71;
   localparam logic [BLEN-1:0] PRE = BLEN'(1) << OEC;

   logic            tck = 1'b0;
   logic            por_n, tms, tdi;
   logic            tdo, tdo_oe, extest_drive, q_oe;
   logic [BLEN-1:0] pin_in, pin_out;

   int n_chk  = 0;
   int n_fail = 0;
   logic done = 1'b0;

   always #10 tck = ~tck;

   scan_port #(.BSR_LEN(BLEN), .OE_CELL(OEC), .ID_VALUE(ID)) dut (
      .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
      .pin_in(pin_in), .pin_out(pin_out), .extest_drive(extest_drive), .q_oe(q_oe)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d);
      tms = m;
      tdi = d;
      @(posedge tck);
      #15;
   endtask

   task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
      dout = '0;
      tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         tick(i == n - 1, din[i]);
      end
      tick(1, 0); tick(0, 0);
   endtask

   task automatic load_ir(input logic [2:0] op, output logic [2:0] capt);
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < 3; i++) begin
         capt[i] = tdo;
         tick(i == 2, op[i]);
      end
      tick(1, 0); tick(0, 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0]     din, dout, exp;
      logic [2:0]      capt;
      logic [BLEN-1:0] exp_pre;
      exp_pre = PRE;
      por_n  = 1'b0;
      tms    = 1'b1;
      tdi    = 1'b0;
      pin_in = '0;
      repeat (3) @(posedge tck);
      #15;
      por_n = 1'b1;

      // R1 R11 R12 reset state
      chk("R11 preset after power-on", 64'(pin_out), 64'(PRE));
      chk("R12 q_oe after power-on", 64'(q_oe), 64'd1);
      chk("R12 extest_drive after power-on", 64'(extest_drive), 64'd0);
      chk("R2 tdo_oe idle", 64'(tdo_oe), 64'd0);
      tick(0, 0);
      shift_dr(32, 64'h0, dout);
      chk("R1 identity selected after power-on", dout[31:0], 64'(ID));

      // sweep every opcode
      for (int op = 0; op < 8; op++) begin
         logic [2:0] code;
         code = 3'(op);
         load_ir(code, capt);
         chk("R3 capture-IR pattern", 64'(capt), 64'd1);
         din = 64'h9D3A_61C5_4E72_B80F ^ (64'h0101_0101_0101_0101 * 64'(op));
         din[47] = 1'b0;
         if (code == 3'b010) begin
            chk("R9 q_oe off under sample-z", 64'(q_oe), 64'd0);
            chk("R9 extest_drive", 64'(extest_drive), 64'd0);
         end else if (code == 3'b000) begin
            chk("R10 extest_drive", 64'(extest_drive), 64'd1);
            chk("R10 q_oe from preload cell", 64'(q_oe), 64'(exp_pre[OEC]));
         end else if (code == 3'b011 || code == 3'b101 || code == 3'b110) begin
            chk("R7 reserved q_oe", 64'(q_oe), 64'd1);
            chk("R7 reserved extest_drive", 64'(extest_drive), 64'd0);
         end else begin
            chk("R12 q_oe", 64'(q_oe), 64'd1);
            chk("R12 extest_drive", 64'(extest_drive), 64'd0);
         end
         if (code == 3'b001) begin
            shift_dr(32, din, dout);
            chk("R6 identity value", dout[31:0], 64'(ID));
         end else if (code == 3'b000 || code == 3'b010 || code == 3'b100) begin
            pin_in = BLEN'({din[31:0], din[63:32]} ^ 64'hFFFF);
            shift_dr(BLEN, din, dout);
            chk("R8 boundary capture of pin_in", dout[BLEN-1:0], 64'(pin_in));
            exp_pre = din[BLEN-1:0];
            chk("R8 preload after update", 64'(pin_out), 64'(exp_pre));
            if (code == 3'b010)
               chk("R9 q_oe stays off", 64'(q_oe), 64'd0);
            if (code == 3'b000)
               chk("R10 q_oe follows cell 47 = 0", 64'(q_oe), 64'd0);
         end else begin
            shift_dr(16, din, dout);
            exp = {din[62:0], 1'b0};
            if (code == 3'b111)
               chk("R5 R4 bypass one-bit delay, captured 0", dout[15:0], exp[15:0]);
            else
               chk("R7 R4 reserved acts as bypass", dout[15:0], exp[15:0]);
         end
      end

      // R10 external test with cell 47 set
      load_ir(3'b000, capt);
      din = 64'h0000_8000_0000_00A5;
      shift_dr(BLEN, din, dout);
      chk("R10 q_oe follows cell 47 = 1", 64'(q_oe), 64'd1);
      chk("R10 pin_out drives preload", 64'(pin_out), 64'(din[BLEN-1:0]));

      // R2 tdo_oe changes on the falling edge
      tick(1, 0); tick(0, 0);
      tms = 1'b0;
      @(posedge tck);
      #2;
      chk("R2 tdo_oe before falling edge", 64'(tdo_oe), 64'd0);
      #13;
      chk("R2 tdo_oe in Shift-DR", 64'(tdo_oe), 64'd1);

      // R1 five tms-high edges from Shift-DR
      for (int k = 0; k < 5; k++) tick(1, 1);
      tick(0, 0);
      chk("R1 instruction back to identity (q_oe)", 64'(q_oe), 64'd1);
      chk("R1 extest_drive cleared", 64'(extest_drive), 64'd0);
      chk("R11 preload preset in Test-Logic-Reset", 64'(pin_out), 64'(PRE));
      shift_dr(32, 64'h0, dout);
      chk("R1 identity after tms reset", dout[31:0], 64'(ID));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule